// File: doc/BRIEF.md
# I2C Passive Bus Monitor

This block watches a two-wire I2C bus without taking part in it. Both bus lines are brought into the system clock domain through synchronizers. The block detects START and STOP conditions and collects each 9-bit frame, which is eight data bits followed by the acknowledge slot. The first byte after a START is an address byte. Its upper seven bits are compared with four programmable slave addresses. A match-all option instead accepts any address.

Once an address is accepted, the block raises an interrupt. After that it raises one interrupt for each further byte of the transfer, in either direction. Software reads the live shift register and a separate capture buffer. The buffer holds the last complete byte for a whole frame, so a slow handler still sees it. The block never pulls SDA low. It may hold SCL low while an interrupt is pending, but only when the control input allows it.

The control input has three fields. `ctrl_i[0]` enables monitoring, `ctrl_i[1]` allows clock stretching and `ctrl_i[2]` selects match-all. Bits 1 and 2 matter only while bit 0 is set.

Top module: `i2c_bus_watch`

## Requirements
- R1: After reset, `irq_o`, `scl_oe_o`, `sda_oe_o`, `rw_o` and `ack_o` are 0, and `data_o` and `buf_o` are 0x00.
- R2: `sda_oe_o` stays 0 at all times, including during acknowledge slots of accepted transfers.
- R3: While `ctrl_i[0]` is 0, no interrupt is raised and `scl_oe_o` stays 0, whatever the values of `ctrl_i[1]` and `ctrl_i[2]`. `buf_o`, `rw_o` and `ack_o` are also left unchanged.
- R4: With `ctrl_i[2]` = 0, an address byte whose upper seven bits equal one of the four 7-bit fields of `slv_addr_i` raises `irq_o` at the ninth SCL rise of that frame. Entry k of `slv_addr_i` is bits [7k+6:7k].
- R5: With `ctrl_i[2]` = 1 and `ctrl_i[0]` = 1, every address byte raises `irq_o`.
- R6: After an accepted address, every later byte raises `irq_o` at its ninth SCL rise. This holds for both write and read transfers.
- R7: A rejected address raises no interrupt, either for the address byte or for the bytes that follow it. Such bytes also leave `buf_o` and `ack_o` untouched.
- R8: A STOP, or a repeated START, ends the current transfer. The next byte is then treated as a new address byte and compared again.
- R9: On each of the first eight SCL rises of a frame, SDA is shifted into `data_o` at the LSB, so the byte arrives MSB first. The ninth rise does not shift.
- R10: `buf_o` loads `data_o` at the ninth SCL rise of every address byte and of every byte of an accepted transfer. It holds that value while the next frame shifts in.
- R11: `rw_o` takes bit 0 of each address byte, where 1 means a read. `ack_o` takes the SDA level of the ninth bit of every frame that loads `buf_o`.
- R12: With `ctrl_i[1:0]` = 2'b11, `scl_oe_o` goes to 1 at the first SCL fall while `irq_o` is set. It returns to 0 one clock after `irq_clr_i` is asserted. With `ctrl_i[1]` = 0, `scl_oe_o` stays 0.
- R13: `irq_o` stays set until `irq_clr_i` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe_o | output | 1 | 1 would pull SDA low; always 0 |
| ctrl_i | input | 3 | [0] monitor enable, [1] stretch allow, [2] match-all |
| slv_addr_i | input | NUM_ADDR*ADDR_W | Four packed 7-bit slave addresses |
| irq_o | output | 1 | Interrupt flag |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| data_o | output | 8 | Live shift register |
| buf_o | output | 8 | Last complete byte, held for a frame |
| rw_o | output | 1 | Direction bit of last address |
| ack_o | output | 1 | Ninth-bit SDA level of last captured frame |

## Verification
The bench aims at four things:
- **Rejected addresses.** It sends bytes after a rejected address. A design that leaks an accept decision into those bytes would raise interrupts or overwrite the capture buffer.
- **Repeated START.** It sends a repeated START followed by a rejected address. A design that keeps the old accept decision would still interrupt.
- **Buffer against shift register.** Part way through a frame, it compares the buffer with the live shift register. A design that ties them together shows the partial byte.
- **Control gating.** It checks the exact clock on which the stretch is released. It also drives the stretch and match-all bits while monitoring is off, and a design that ignores the enable gating would hold SCL or interrupt.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_SKIP
  } mon_state_e;

  localparam int CTRL_W = 3;
  localparam int CTRL_MON = 0;
  localparam int CTRL_STRETCH = 1;
  localparam int CTRL_ANY = 2;
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= 1'b1;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cw_cond.sv
module i2cw_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cw_addr_match.sv
module i2cw_addr_match #(
  parameter int ADDR_W   = 7,
  parameter int NUM_ADDR = 4
) (
  input  logic [ADDR_W-1:0]          cand,
  input  logic [NUM_ADDR*ADDR_W-1:0] table_i,
  output logic                       hit
);
  logic [NUM_ADDR-1:0] eq;

  genvar k;
  generate
    for (k = 0; k < NUM_ADDR; k++) begin : g_cmp
      assign eq[k] = (table_i[k*ADDR_W +: ADDR_W] == cand);
    end
  endgenerate

  assign hit = |eq;
endmodule

// File: rtl/i2cw_frame.sv
module i2cw_frame
  import i2cw_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mon_en,
  input  logic              scl_rise,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic              addr_ok,
  output logic [BYTE_W-1:0] shift_o,
  output logic [BYTE_W-1:0] hold_o,
  output logic              rw_o,
  output logic              ack_o,
  output logic              event_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  mon_state_e       state;
  logic [CNT_W-1:0] bit_cnt;
  logic             slot_end;
  logic             capture;

  assign slot_end = mon_en & scl_rise & ~start_det & ~stop_det
                  & (state != ST_IDLE) & (bit_cnt == LAST_BIT);
  assign capture  = slot_end & ((state == ST_ADDR) | (state == ST_DATA));
  assign event_o  = slot_end & ((state == ST_DATA) | ((state == ST_ADDR) & addr_ok));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      shift_o <= '0;
      hold_o  <= '0;
      rw_o    <= 1'b0;
      ack_o   <= 1'b0;
    end else if (!mon_en) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
    end else if (start_det) begin
      state   <= ST_ADDR;
      bit_cnt <= '0;
    end else if (stop_det) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
    end else if (scl_rise && state != ST_IDLE) begin
      if (bit_cnt == LAST_BIT) begin
        bit_cnt <= '0;
        if (capture) begin
          hold_o <= shift_o;
          ack_o  <= sda_s;
        end
        if (state == ST_ADDR) begin
          rw_o  <= shift_o[0];
          state <= addr_ok ? ST_DATA : ST_SKIP;
        end
      end else begin
        shift_o <= {shift_o[BYTE_W-2:0], sda_s};
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
  import i2cw_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int NUM_ADDR    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       scl_oe_o,
  output logic                       sda_oe_o,
  input  logic [CTRL_W-1:0]          ctrl_i,
  input  logic [NUM_ADDR*ADDR_W-1:0] slv_addr_i,
  output logic                       irq_o,
  input  logic                       irq_clr_i,
  output logic [ADDR_W:0]            data_o,
  output logic [ADDR_W:0]            buf_o,
  output logic                       rw_o,
  output logic                       ack_o
);
  localparam int BYTE_W = ADDR_W + 1;

  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic cmp_hit, addr_ok, event_w;
  logic mon_en, stretch_en;
  logic irq_q, hold_q;
  logic [BYTE_W-1:0] shift_w;

  assign mon_en     = ctrl_i[CTRL_MON];
  assign stretch_en = ctrl_i[CTRL_MON] & ctrl_i[CTRL_STRETCH];

  i2cw_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
    .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s)
  );
  i2cw_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
    .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s)
  );

  i2cw_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cw_addr_match #(.ADDR_W(ADDR_W), .NUM_ADDR(NUM_ADDR)) u_match (
    .cand(shift_w[BYTE_W-1:1]), .table_i(slv_addr_i), .hit(cmp_hit)
  );

  assign addr_ok = ctrl_i[CTRL_ANY] | cmp_hit;

  i2cw_frame #(.BYTE_W(BYTE_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .mon_en(mon_en),
    .scl_rise(scl_rise), .start_det(start_det), .stop_det(stop_det),
    .sda_s(sda_s), .addr_ok(addr_ok),
    .shift_o(shift_w), .hold_o(buf_o), .rw_o(rw_o), .ack_o(ack_o),
    .event_o(event_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= event_w | (irq_q & ~irq_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        hold_q <= 1'b0;
    else if (irq_clr_i || !stretch_en) hold_q <= 1'b0;
    else if (scl_fall && irq_q)        hold_q <= 1'b1;
  end

  assign irq_o    = irq_q;
  assign scl_oe_o = hold_q;
  assign sda_oe_o = 1'b0;
  assign data_o   = shift_w;
endmodule

// File: rtl/i2c_bus_watch_chk.sv
module i2c_bus_watch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] ctrl_i,
  input logic       irq_o,
  input logic       irq_clr_i,
  input logic       scl_oe_o
);
  AST_OFF_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_i[0] |=> !$rose(irq_o)); // R3

  AST_OFF_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_i[0] |=> !scl_oe_o); // R3

  AST_NO_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_i[1] |=> !scl_oe_o); // R12

  AST_CLR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr_i |=> !scl_oe_o); // R12

  AST_HOLD_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe_o |-> irq_o); // R12

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_clr_i) |=> irq_o); // R13
endmodule

bind i2c_bus_watch i2c_bus_watch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl_i), .irq_o(irq_o),
  .irq_clr_i(irq_clr_i), .scl_oe_o(scl_oe_o)
);

// File: tb/i2c_bus_watch_tb.sv
module i2c_bus_watch_tb;
  localparam int T = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic [2:0] ctrl = 3'b000;
  logic clr = 1'b0;
  logic scl_oe, sda_oe, irq, rw, ack;
  logic [7:0] data, bufv;
  logic scl_line;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // slots: 0x12, 0x34, 0x56, 0x78
  localparam logic [27:0] ADDRS = {7'h78, 7'h56, 7'h34, 7'h12};

  always #2 clk = ~clk;
  assign scl_line = m_scl & ~scl_oe;

  i2c_bus_watch u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(m_sda),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .ctrl_i(ctrl),
    .slv_addr_i(ADDRS), .irq_o(irq), .irq_clr_i(clr),
    .data_o(data), .buf_o(bufv), .rw_o(rw), .ack_o(ack)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_bit(input logic b);
    m_sda = b; tick(T);
    m_scl = 1'b1;
    while (scl_oe) tick(1);
    tick(T);
    m_scl = 1'b0; tick(T);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; tick(T);
    m_scl = 1'b1; tick(T);
    m_sda = 1'b0; tick(T);
    m_scl = 1'b0; tick(T);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; tick(T);
    m_scl = 1'b1; tick(T);
    m_sda = 1'b1; tick(T);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic a);
    for (int i = 7; i >= 0; i--) bus_bit(b[i]);
    bus_bit(a);
    chk("R2 sda_oe", sda_oe, 0);
  endtask

  task automatic clear_irq;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  // {ctrl[2:0], addr byte, data byte, irq after addr, irq after data}
  localparam int NV = 9;
  localparam logic [20:0] VEC [NV] = '{
    {3'b001, 8'h24, 8'hA5, 1'b1, 1'b1},
    {3'b001, 8'h69, 8'h3C, 1'b1, 1'b1},
    {3'b001, 8'hAC, 8'h00, 1'b1, 1'b1},
    {3'b001, 8'hF1, 8'hFF, 1'b1, 1'b1},
    {3'b001, 8'h20, 8'h5A, 1'b0, 1'b0},
    {3'b101, 8'h20, 8'h5A, 1'b1, 1'b1},
    {3'b110, 8'h24, 8'h77, 1'b0, 1'b0},
    {3'b011, 8'h24, 8'h81, 1'b1, 1'b1},
    {3'b101, 8'hFE, 8'h42, 1'b1, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] e_buf;
    logic e_rw, e_ack;
    e_buf = 8'h00; e_rw = 1'b0; e_ack = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(2);
    chk("R1 irq", irq, 0);
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 data", data, 0);
    chk("R1 buf", bufv, 0);
    chk("R1 rw", rw, 0);
    chk("R1 ack", ack, 0);

    // table walk: R3 R4 R5 R6 R7 R10 R11 R12
    for (int v = 0; v < NV; v++) begin
      logic [2:0] c;
      logic [7:0] ab, db;
      logic ea, ed;
      {c, ab, db, ea, ed} = VEC[v];
      ctrl = c;
      tick(2);
      bus_start;
      send_byte(ab, 1'b0);
      if (c[0]) begin e_buf = ab; e_rw = ab[0]; e_ack = 1'b0; end
      chk("R4 R5 R7 R3 irq after address", irq, ea);
      chk("R12 scl_oe after address", scl_oe, ea & c[1] & c[0]);
      chk("R10 buf after address", bufv, e_buf);
      chk("R11 rw", rw, e_rw);
      if (irq) clear_irq;
      send_byte(db, 1'b1);
      if (ea) begin e_buf = db; e_ack = 1'b1; end
      chk("R6 R7 R3 irq after data", irq, ed);
      chk("R12 scl_oe after data", scl_oe, ed & c[1] & c[0]);
      chk("R10 R7 buf after data", bufv, e_buf);
      chk("R11 ack", ack, e_ack);
      if (irq) clear_irq;
      bus_stop;
    end

    // R12: release exactly one clock after clear
    ctrl = 3'b011;
    bus_start;
    send_byte(8'h68, 1'b0);
    chk("R12 held before clear", scl_oe, 1);
    @(negedge clk); clr = 1'b1;
    chk("R12 still held in clear cycle", scl_oe, 1);
    @(negedge clk); clr = 1'b0;
    chk("R12 released one clock later", scl_oe, 0);
    chk("R13 irq cleared", irq, 0);
    // R9/R10: partial frame
    send_byte(8'hC3, 1'b0);
    clear_irq;
    bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
    chk("R9 data mid-frame", data, 8'h1D);
    chk("R10 buf holds mid-frame", bufv, 8'hC3);
    for (int i = 0; i < 5; i++) bus_bit(1'b0);
    chk("R9 data full byte", data, 8'hA0);
    bus_bit(1'b1);
    chk("R10 buf after frame", bufv, 8'hA0);
    chk("R6 irq", irq, 1);
    clear_irq;
    bus_stop;

    // R13: flag persists without clear; R8: repeated START re-evaluates
    ctrl = 3'b001;
    bus_start;
    send_byte(8'h24, 1'b0);
    tick(60);
    chk("R13 irq sticky", irq, 1);
    clear_irq;
    send_byte(8'h11, 1'b0);
    chk("R6 irq data", irq, 1);
    clear_irq;
    bus_start;
    send_byte(8'h20, 1'b0);
    chk("R8 rejected after repeated START", irq, 0);
    send_byte(8'h99, 1'b0);
    chk("R8 R7 no irq on skipped data", irq, 0);
    chk("R7 buf kept", bufv, 8'h20);
    bus_start;
    send_byte(8'hF0, 1'b0);
    chk("R8 new address accepted", irq, 1);
    clear_irq;
    bus_stop;

    // R3: disabled leaves status untouched, even with bits 1 and 2 set
    ctrl = 3'b110;
    bus_start;
    send_byte(8'h25, 1'b1);
    chk("R3 irq off", irq, 0);
    chk("R3 scl_oe off", scl_oe, 0);
    chk("R3 buf kept", bufv, 8'hF0);
    chk("R3 rw kept", rw, 0);
    bus_stop;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule